// File: doc/BRIEF.md
# Clocked Synchronous Serial Receiver

This block is the receive half of a clocked serial link in which the remote end supplies the bit clock. The block passes the serial clock and data inputs through a synchronizer. On each rising edge of the serial clock it shifts in one data bit, least significant bit first. After eight bits it moves the byte into a holding register, sets a receive-full flag and pulses an interrupt request. Either a CPU or a DMA engine then collects the byte. A DMA read of the holding register clears the full flag by itself. The CPU clears a flag with a clear strobe, and that strobe only counts if a status read earlier saw the flag set.

If a byte has not been collected by the time the last bit of the next frame arrives, the block raises an overrun flag. It keeps the older byte, drops the new one and stops receiving until the overrun flag is cleared. A sequencer with three states controls reception:

- `IDLE`: reception is disabled, or waiting for permission.
- `SHIFT`: bits are being collected.
- `HALT`: frozen after an overrun.

It has five transitions:

- `IDLE→SHIFT`: enable is high and both flags are clear.
- `SHIFT→IDLE`: enable falls.
- `SHIFT→HALT`: a frame completes while the full flag is still set.
- `HALT→SHIFT`: the overrun flag has been cleared while enable is high.
- `HALT→IDLE`: enable falls.

Top module: `sync_ser_rx`

## Requirements
- R1: The data input is sampled on each rising edge of the serial clock, LSB first. After 8 bits the assembled byte appears on `rd_data`, with the first bit received in bit 0.
- R2: When a frame completes and the full flag is clear, or is being cleared in that same cycle, `full` goes to 1 together with the new byte.
- R3: `irq` is high for exactly one clock each time a byte is loaded, which is when `full` goes from 0 to 1. It is low otherwise.
- R4: When a frame completes while `full` is still set and not being cleared in that cycle, `ovr` goes to 1 and `rd_data` keeps the earlier byte.
- R5: While `ovr` is 1, serial input is ignored: `rd_data`, `full` and `irq` stay unchanged. After `ovr` is cleared with enable high, a fresh frame starts at the next rising serial-clock edge.
- R6: A `dma_rd` pulse clears `full` on the next clock.
- R7: `cpu_clr_full` or `cpu_clr_ovr` clears its flag only if a `cpu_rd_status` pulse saw that flag at 1 earlier. Without that read the clear strobe has no effect.
- R8: While `rx_en` is low, the bit count is held at zero and the shift register does not change. A partly received frame is discarded, and the next enabled frame is assembled from bit 0.
- R9: When enable is raised from the idle state, reception starts only once both `full` and `ovr` are 0. Until then, serial input is ignored.
- R10: After reset, `full`, `ovr` and `irq` are 0 and `rd_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable |
| sclk | input | 1 | Serial clock from the remote end |
| sdata | input | 1 | Serial data, valid at the rising edge of `sclk` |
| cpu_rd_status | input | 1 | CPU status read; arms the clear of any flag that is 1 |
| cpu_clr_full | input | 1 | CPU request to clear `full` |
| cpu_clr_ovr | input | 1 | CPU request to clear `ovr` |
| dma_rd | input | 1 | DMA read of the data register; clears `full` |
| rd_data | output | 8 | Receive data register |
| full | output | 1 | Receive-full flag |
| ovr | output | 1 | Overrun flag |
| irq | output | 1 | One-cycle receive interrupt request |

## Verification
The bench sends a second byte without collecting the first. A design that judged overrun at the first bit instead of the last, or that overwrote the register, would show the wrong byte or raise `ovr` early. Frames sent while `ovr` is set must leave the register and the interrupt count untouched; a design that kept shifting would also resume in the middle of a frame after the clear. The bench drops enable in the middle of a frame and issues a clear strobe without the status read first. It also re-enables while `full` is set; a design without the entry guard would accept that byte.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_SHIFT = 2'd1,
        RX_HALT  = 2'd2
    } rx_state_e;
endpackage

// File: rtl/sync_rx_sync.sv
module sync_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic sdata,
    output logic sclk_rise,
    output logic bit_val
);
    logic [STAGES-1:0] sck_q;
    logic [STAGES-1:0] dat_q;
    logic              sck_prev;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sck_q <= '0;
                    dat_q <= '0;
                end else begin
                    sck_q <= sclk;
                    dat_q <= sdata;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sck_q <= '0;
                    dat_q <= '0;
                end else begin
                    sck_q <= {sck_q[STAGES-2:0], sclk};
                    dat_q <= {dat_q[STAGES-2:0], sdata};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_prev <= 1'b0;
        else        sck_prev <= sck_q[STAGES-1];
    end

    assign sclk_rise = sck_q[STAGES-1] & ~sck_prev;
    assign bit_val   = dat_q[STAGES-1];
endmodule

// File: rtl/sync_rx_shift.sv
module sync_rx_shift #(
    parameter int WIDTH = 8,
    localparam int CW   = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shifting,
    input  logic             sclk_rise,
    input  logic             bit_val,
    output logic             frame_done,
    output logic [WIDTH-1:0] frame_byte
);
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    logic [WIDTH-1:0] sr_q;
    logic [CW-1:0]    cnt_q;

    assign frame_byte = {bit_val, sr_q[WIDTH-1:1]};
    assign frame_done = shifting & sclk_rise & (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (!shifting) begin
            cnt_q <= '0;
        end else if (sclk_rise) begin
            sr_q  <= frame_byte;
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    p_idle_cnt_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !shifting |=> cnt_q == '0);
    p_idle_sr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !shifting |=> $stable(sr_q));
endmodule

// File: rtl/sync_rx_flags.sv
module sync_rx_flags #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_done,
    input  logic [WIDTH-1:0] frame_byte,
    input  logic             cpu_rd_status,
    input  logic             cpu_clr_full,
    input  logic             cpu_clr_ovr,
    input  logic             dma_rd,
    output logic             ovr_hit,
    output logic [WIDTH-1:0] rdr,
    output logic             full,
    output logic             ovr,
    output logic             irq
);
    logic arm_full_q, arm_ovr_q;
    logic full_eff, ovr_eff, load, full_n, ovr_n;

    always_comb begin
        full_eff = full & ~(cpu_clr_full & arm_full_q) & ~dma_rd;
        ovr_eff  = ovr & ~(cpu_clr_ovr & arm_ovr_q);
        load     = frame_done & ~full_eff;
        ovr_hit  = frame_done & full_eff;
        full_n   = full_eff | load;
        ovr_n    = ovr_eff | ovr_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdr        <= '0;
            full       <= 1'b0;
            ovr        <= 1'b0;
            irq        <= 1'b0;
            arm_full_q <= 1'b0;
            arm_ovr_q  <= 1'b0;
        end else begin
            full <= full_n;
            ovr  <= ovr_n;
            irq  <= load;
            if (load) rdr <= frame_byte;
            if (!full_n)                    arm_full_q <= 1'b0;
            else if (cpu_rd_status && full) arm_full_q <= 1'b1;
            if (!ovr_n)                     arm_ovr_q  <= 1'b0;
            else if (cpu_rd_status && ovr)  arm_ovr_q  <= 1'b1;
        end
    end

    p_irq_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> irq);
    p_full_from_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> $past(frame_done));
    p_ovr_keeps_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $stable(rdr));
    p_dma_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_rd && !frame_done) |=> !full);
    p_clear_needs_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !arm_full_q && !dma_rd) |=> full);
endmodule

// File: rtl/sync_ser_rx.sv
module sync_ser_rx #(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic             sclk,
    input  logic             sdata,
    input  logic             cpu_rd_status,
    input  logic             cpu_clr_full,
    input  logic             cpu_clr_ovr,
    input  logic             dma_rd,
    output logic [WIDTH-1:0] rd_data,
    output logic             full,
    output logic             ovr,
    output logic             irq
);
    import sync_rx_pkg::*;

    rx_state_e        state_q, state_n;
    logic             sclk_rise, bit_val, shifting, frame_done, ovr_hit;
    logic [WIDTH-1:0] frame_byte;

    sync_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata),
        .sclk_rise(sclk_rise), .bit_val(bit_val)
    );

    sync_rx_shift #(.WIDTH(WIDTH)) u_shift (
        .clk(clk), .rst_n(rst_n), .shifting(shifting),
        .sclk_rise(sclk_rise), .bit_val(bit_val),
        .frame_done(frame_done), .frame_byte(frame_byte)
    );

    sync_rx_flags #(.WIDTH(WIDTH)) u_flags (
        .clk(clk), .rst_n(rst_n), .frame_done(frame_done),
        .frame_byte(frame_byte), .cpu_rd_status(cpu_rd_status),
        .cpu_clr_full(cpu_clr_full), .cpu_clr_ovr(cpu_clr_ovr),
        .dma_rd(dma_rd), .ovr_hit(ovr_hit), .rdr(rd_data),
        .full(full), .ovr(ovr), .irq(irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            RX_IDLE:  if (rx_en && !full && !ovr) state_n = RX_SHIFT;
            RX_SHIFT: if (!rx_en)                 state_n = RX_IDLE;
                      else if (ovr_hit)           state_n = RX_HALT;
            RX_HALT:  if (!rx_en)                 state_n = RX_IDLE;
                      else if (!ovr)              state_n = RX_SHIFT;
            default:                              state_n = RX_IDLE;
        endcase
    end

    always_comb begin
        shifting = (state_q == RX_SHIFT) && rx_en;
    end

    p_frozen_on_ovr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |=> $stable(rd_data));
    p_halt_after_ovr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && $rose(ovr)) |-> state_q == RX_HALT);
    p_entry_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_IDLE && (full || ovr)) |=> state_q == RX_IDLE);
endmodule

// File: tb/sim_sync_ser_rx.sv
module sim_sync_ser_rx;
    localparam int N = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0, sclk = 1'b0, sdata = 1'b0;
    logic       cpu_rd_status = 1'b0, cpu_clr_full = 1'b0, cpu_clr_ovr = 1'b0, dma_rd = 1'b0;
    logic [7:0] rd_data;
    logic       full, ovr, irq;

    int n_chk = 0, n_fail = 0, cyc = 0, irq_cnt = 0;

    always #2 clk = ~clk;

    sync_ser_rx #(.WIDTH(8), .SYNC_STAGES(N)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .sclk(sclk), .sdata(sdata),
        .cpu_rd_status(cpu_rd_status), .cpu_clr_full(cpu_clr_full),
        .cpu_clr_ovr(cpu_clr_ovr), .dma_rd(dma_rd),
        .rd_data(rd_data), .full(full), .ovr(ovr), .irq(irq)
    );

    // behavioural reference model
    bit   qs[$], qd[$];
    bit   m_prev, m_full, m_ovr, m_irq, m_armf, m_armo;
    int   m_st, m_cnt;
    bit [7:0] m_sr, m_rdr;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qs.delete(); qd.delete();
            for (int i = 0; i < N; i++) begin qs.push_back(1'b0); qd.push_back(1'b0); end
            m_prev = 0; m_full = 0; m_ovr = 0; m_irq = 0; m_armf = 0; m_armo = 0;
            m_st = 0; m_cnt = 0; m_sr = 0; m_rdr = 0;
        end else begin
            bit sy, dy, rise, sh, fd, fe, oe, hit, nf, no;
            bit [7:0] nb;
            sy = qs[0]; dy = qd[0];
            rise = sy && !m_prev;
            sh = (m_st == 1) && rx_en;
            fd = rise && sh && (m_cnt == 7);
            nb = {dy, m_sr[7:1]};
            fe = m_full && !(cpu_clr_full && m_armf) && !dma_rd;
            oe = m_ovr && !(cpu_clr_ovr && m_armo);
            hit = fd && fe;
            nf = fe || fd;
            no = oe || hit;
            m_irq = fd && !fe;
            if (fd && !fe) m_rdr = nb;
            if (!nf) m_armf = 0; else if (cpu_rd_status && m_full) m_armf = 1;
            if (!no) m_armo = 0; else if (cpu_rd_status && m_ovr) m_armo = 1;
            case (m_st)
                0: if (rx_en && !m_full && !m_ovr) m_st = 1;
                1: if (!rx_en) m_st = 0; else if (hit) m_st = 2;
                default: if (!rx_en) m_st = 0; else if (!m_ovr) m_st = 1;
            endcase
            if (!sh) m_cnt = 0;
            else if (rise) begin m_sr = nb; m_cnt = (m_cnt == 7) ? 0 : m_cnt + 1; end
            m_full = nf; m_ovr = no;
            m_prev = sy;
            void'(qs.pop_front()); qs.push_back(sclk);
            void'(qd.pop_front()); qd.push_back(sdata);
        end
    end

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk("R1 rd_data vs model", rd_data, m_rdr);
            chk("R2 full vs model", full, m_full);
            chk("R4 ovr vs model", ovr, m_ovr);
            chk("R3 irq vs model", irq, m_irq);
            if (irq) irq_cnt++;
        end
        if (cyc > 100000) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=%0d expected<=100000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic clks(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(bit [7:0] b, int nbits);
        for (int i = 0; i < nbits; i++) begin
            sdata = b[i]; sclk = 1'b0; clks(4);
            sclk = 1'b1; clks(4);
        end
        sclk = 1'b0;
        clks(4);
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1; clks(1); s = 1'b0; clks(1);
    endtask

    initial begin
        int ic;
        clks(3);
        rst_n = 1'b1;
        clks(2);
        // R10 reset state
        chk("R10 full", full, 0); chk("R10 ovr", ovr, 0);
        chk("R10 irq", irq, 0);   chk("R10 rd_data", rd_data, 8'h00);

        // R1 R2 R3 basic frame
        rx_en = 1'b1; clks(2);
        send_bits(8'hA5, 8);
        chk("R1 byte LSB first", rd_data, 8'hA5);
        chk("R2 full set", full, 1);
        chk("R3 one irq", irq_cnt, 1);

        // R6 DMA read clears full
        pulse(dma_rd);
        chk("R6 dma clears full", full, 0);

        // R7 clear without read ignored, then honoured after read
        send_bits(8'h3C, 8);
        chk("R1 second byte", rd_data, 8'h3C);
        pulse(cpu_clr_full);
        chk("R7 clear without read ignored", full, 1);
        pulse(cpu_rd_status);
        pulse(cpu_clr_full);
        chk("R7 clear after read", full, 0);

        // R4 overrun keeps earlier byte
        send_bits(8'h11, 8);
        send_bits(8'h22, 8);
        chk("R4 ovr set", ovr, 1);
        chk("R4 older byte kept", rd_data, 8'h11);

        // R5 frozen while overrun flag set
        ic = irq_cnt;
        pulse(dma_rd);
        send_bits(8'h33, 8);
        chk("R5 data frozen", rd_data, 8'h11);
        chk("R5 full stays clear", full, 0);
        chk("R5 no irq", irq_cnt, ic);
        pulse(cpu_clr_ovr);
        chk("R7 ovr clear without read ignored", ovr, 1);
        pulse(cpu_rd_status);
        pulse(cpu_clr_ovr);
        chk("R5 ovr cleared", ovr, 0);
        send_bits(8'h44, 8);
        chk("R5 resumes fresh frame", rd_data, 8'h44);

        // R8 partial frame dropped by disable
        pulse(dma_rd);
        send_bits(8'hFF, 3);
        rx_en = 1'b0; clks(6);
        send_bits(8'h0F, 2);
        chk("R8 nothing while disabled", full, 0);
        rx_en = 1'b1; clks(2);
        send_bits(8'h5A, 8);
        chk("R8 fresh frame after re-enable", rd_data, 8'h5A);

        // R9 re-enable with full set stays idle
        rx_en = 1'b0; clks(4);
        rx_en = 1'b1; clks(2);
        send_bits(8'h77, 8);
        chk("R9 byte ignored", rd_data, 8'h5A);
        chk("R9 no overrun", ovr, 0);
        pulse(dma_rd);
        clks(2);
        send_bits(8'h66, 8);
        chk("R9 receives after flags clear", rd_data, 8'h66);
        chk("R2 full after resume", full, 1);

        clks(4);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule